// File: doc/BRIEF.md
# Line-Counted Exposure Sequencer

This block drives the exposure control lines of a global-shutter image sensor whose readout runs on its own internal timing. Exposure events are not timed in clock cycles but in readout lines: every completed line of the frame now being read advances a line counter. That counter is compared with four programmed thresholds. The first releases the pixel reset, which starts integration. The second and third fire the two extra reset pulses used for dual-slope and triple-slope exposure. The fourth fires the frame-transfer pulse, which opens the frame overhead period.

Each threshold holds the number of lines minus one. A value of T is acted on when the (T+1)th line-done strobe of the frame arrives. All three pulses share one width, set by a 2-bit granularity code. The thresholds and the granularity are captured when a frame starts, so register writes made during a frame have no effect until the next one. The pixel reset is raised again by the frame-transfer pulse and stays high until the release threshold of a later frame is reached.

Top module: `line_exposure_seq`

## Requirements
- R1: After reset `pix_rst` is 1 and `ds_pulse`, `ts_pulse` and `xfer_pulse` are 0. Until the first `frame_start`, line strobes trigger no event.
- R2: A threshold of value T (12 bits, lines minus one) is acted on at the (T+1)th `line_done` after `frame_start`. The output changes in the cycle after the clock edge that samples that strobe.
- R3: Every pulse stays high for exactly 4*(12*(g+1)+1) cycles, where g is the granularity code captured at frame start. This gives 52, 100, 148 and 196 cycles for g = 0, 1, 2 and 3.
- R4: `pix_rst` falls on the release match. It rises when a frame-transfer pulse starts and then stays high until the next release match. It is always high while `xfer_pulse` is high. If release and transfer match on the same line, `pix_rst` is held high only by the transfer pulse and is low after that pulse ends.
- R5: Within one frame, each threshold is acted on at most once.
- R6: A running pulse completes its full width regardless of line strobes or frame starts that arrive while it runs.
- R7: Thresholds that match on the same line start their pulses in the same cycle. Each pulse then completes its own full width.
- R8: The thresholds and the granularity are sampled on `frame_start`. Changing the inputs during a frame has no effect within that frame.
- R9: A `line_done` in the same cycle as `frame_start` is dropped. The line count of the new frame starts at zero.
- R10: The line counter saturates at 4095. A threshold of 4095 is acted on at the 4096th strobe, and further strobes do not trigger it again.
- R11: A match for a pulse that is still running is ignored. The running pulse is neither extended nor restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start of a frame readout; captures the settings and clears the line count |
| line_done | input | 1 | One-cycle strobe for each completed readout line |
| release_line | input | 12 | Line (minus one) at which the pixel reset is released |
| ds_line | input | 12 | Line (minus one) for the dual-slope reset pulse |
| ts_line | input | 12 | Line (minus one) for the triple-slope reset pulse |
| xfer_line | input | 12 | Line (minus one) for the frame-transfer pulse |
| gran | input | 2 | Pulse-width granularity code |
| pix_rst | output | 1 | Pixel reset, high means held in reset |
| ds_pulse | output | 1 | Dual-slope reset pulse |
| ts_pulse | output | 1 | Triple-slope reset pulse |
| xfer_pulse | output | 1 | Frame-transfer / overhead pulse |

## Verification
Two things can happen in the same cycle here. Two or three thresholds can match on the same line. The release of the pixel reset can also coincide with the start of the frame transfer. The bench sets the dual-slope, triple-slope and transfer thresholds to the same line, and then sets the release and transfer thresholds both to 4095. In the first case all pulses must rise on the same cycle and each must keep its full width. In the second case `pix_rst` must stay high exactly as long as the transfer pulse runs and must then fall. A behavioural model checks every cycle, and explicit checks confirm both outcomes.

// File: rtl/line_exposure_seq.sv
module line_exposure_seq #(
  parameter int LINE_W = 12,
  parameter int GRAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_done,
  input  logic [LINE_W-1:0] release_line,
  input  logic [LINE_W-1:0] ds_line,
  input  logic [LINE_W-1:0] ts_line,
  input  logic [LINE_W-1:0] xfer_line,
  input  logic [GRAN_W-1:0] gran,
  output logic              pix_rst,
  output logic              ds_pulse,
  output logic              ts_pulse,
  output logic              xfer_pulse
);
  localparam int NEV  = 4;
  localparam int NPUL = NEV - 1;
  localparam int WMAX = 4 * (12 * (1 << GRAN_W) + 1);
  localparam int RW   = $clog2(WMAX + 1);
  localparam int EV_REL = 0;
  localparam int PU_XF  = 2;
  localparam logic [LINE_W-1:0] LINE_ONE = {{(LINE_W-1){1'b0}}, 1'b1};

  logic [LINE_W-1:0] thr_in [NEV];
  logic [LINE_W-1:0] thr_q  [NEV];
  logic [LINE_W-1:0] line_q;
  logic [GRAN_W-1:0] gran_q;
  logic [NEV-1:0]    armed_q;
  logic [NEV-1:0]    hit;
  logic [RW-1:0]     width;
  logic [RW-1:0]     rem_q [NPUL];
  logic [NPUL-1:0]   start;
  logic [NPUL-1:0]   active;
  logic              hold_q;

  assign thr_in[0] = release_line;
  assign thr_in[1] = ds_line;
  assign thr_in[2] = ts_line;
  assign thr_in[3] = xfer_line;

  assign width = RW'(4 * (12 * (int'(gran_q) + 1) + 1));

  for (genvar e = 0; e < NEV; e++) begin : g_match
    assign hit[e] = armed_q[e] & line_done & ~frame_start & (line_q == thr_q[e]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      gran_q  <= '0;
      armed_q <= '0;
      for (int i = 0; i < NEV; i++) thr_q[i] <= '0;
    end else if (frame_start) begin
      line_q  <= '0;
      gran_q  <= gran;
      armed_q <= '1;
      for (int i = 0; i < NEV; i++) thr_q[i] <= thr_in[i];
    end else begin
      armed_q <= armed_q & ~hit;
      if (line_done && line_q != '1) line_q <= line_q + LINE_ONE;
    end
  end

  for (genvar p = 0; p < NPUL; p++) begin : g_pulse
    assign active[p] = rem_q[p] != '0;
    assign start[p]  = hit[p+1] & ~active[p];
    always_ff @(posedge clk) begin
      if (!rst_n)         rem_q[p] <= '0;
      else if (start[p])  rem_q[p] <= width;
      else if (active[p]) rem_q[p] <= rem_q[p] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             hold_q <= 1'b1;
    else if (hit[EV_REL])   hold_q <= 1'b0;
    else if (start[PU_XF])  hold_q <= 1'b1;
  end

  assign ds_pulse   = active[0];
  assign ts_pulse   = active[1];
  assign xfer_pulse = active[2];
  assign pix_rst    = hold_q | active[PU_XF];
endmodule

// File: rtl/exposure_seq_checks.sv
module exposure_seq_checks #(
  parameter int GRAN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_done,
  input logic [GRAN_W-1:0] gran,
  input logic              pix_rst,
  input logic              ds_pulse,
  input logic              ts_pulse,
  input logic              xfer_pulse
);
  logic [GRAN_W-1:0] gran_l;
  int                run, wexp;
  logic              xf_prev, ds_prev, ds_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gran_l <= '0; run <= 0; wexp <= 0;
      xf_prev <= 1'b0; ds_prev <= 1'b0; ds_seen <= 1'b0;
    end else begin
      if (frame_start) gran_l <= gran;
      xf_prev <= xfer_pulse;
      ds_prev <= ds_pulse;
      if (xfer_pulse && !xf_prev) wexp <= 4 * (12 * (int'(gran_l) + 1) + 1);
      run <= xfer_pulse ? run + 1 : 0;
      ds_seen <= frame_start ? 1'b0 : ((ds_pulse && !ds_prev) ? 1'b1 : ds_seen);
    end
  end

  a_r2_ds_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_pulse) |-> ($past(line_done) && !$past(frame_start)));
  a_r2_ts_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ts_pulse) |-> ($past(line_done) && !$past(frame_start)));
  a_r2_xf_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_pulse) |-> ($past(line_done) && !$past(frame_start)));
  a_r3_xfer_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_pulse) |-> (run == wexp));
  a_r4_pix_during_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> pix_rst);
  a_r4_pix_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_rst) |-> ($past(line_done) || $fell(xfer_pulse)));
  a_r5_ds_once: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_pulse) |-> !ds_seen);
endmodule

bind line_exposure_seq exposure_seq_checks #(.GRAN_W(GRAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
  .gran(gran), .pix_rst(pix_rst), .ds_pulse(ds_pulse), .ts_pulse(ts_pulse),
  .xfer_pulse(xfer_pulse)
);

// File: tb/sim_line_exposure_seq.sv
module sim_line_exposure_seq;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, line_done = 1'b0;
  logic [11:0] t_rel = '0, t_ds = '0, t_ts = '0, t_xf = '0;
  logic [1:0]  gran = '0;
  logic pix_rst, ds_pulse, ts_pulse, xfer_pulse;

  line_exposure_seq u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
    .release_line(t_rel), .ds_line(t_ds), .ts_line(t_ts), .xfer_line(t_xf),
    .gran(gran), .pix_rst(pix_rst), .ds_pulse(ds_pulse), .ts_pulse(ts_pulse),
    .xfer_pulse(xfer_pulse)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";
  bit finished = 0;

  int mcnt, mg, mthr[4], mrem[4];
  bit marm[4], mhold, h[4], s3;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mcnt = 0; mg = 0; mhold = 1;
      for (int i = 0; i < 4; i++) begin marm[i] = 0; mrem[i] = 0; mthr[i] = 0; end
    end else begin
      for (int i = 0; i < 4; i++) h[i] = marm[i] && line_done && !frame_start && (mcnt == mthr[i]);
      s3 = h[3] && (mrem[3] == 0);
      for (int i = 1; i < 4; i++) begin
        if (h[i] && mrem[i] == 0) mrem[i] = 48 * mg + 52;
        else if (mrem[i] > 0) mrem[i]--;
      end
      if (h[0]) mhold = 0;
      else if (s3) mhold = 1;
      for (int i = 0; i < 4; i++) if (h[i]) marm[i] = 0;
      if (frame_start) begin
        mthr[0] = t_rel; mthr[1] = t_ds; mthr[2] = t_ts; mthr[3] = t_xf;
        mg = gran; mcnt = 0;
        for (int i = 0; i < 4; i++) marm[i] = 1;
      end else if (line_done && mcnt < 4095) mcnt++;
    end
  end

  int rise_c[3], last_len[3];
  logic [2:0] prv = '0;
  always @(negedge clk) begin
    logic [3:0] exp_v, act_v;
    logic [2:0] cur;
    if (rst_n) begin
      exp_v = {mhold || mrem[3] > 0, mrem[1] > 0, mrem[2] > 0, mrem[3] > 0};
      act_v = {pix_rst, ds_pulse, ts_pulse, xfer_pulse};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s cycle %0d {pix,ds,ts,xf} actual=%b expected=%b", phase, cyc, act_v, exp_v);
      end
      cur = {xfer_pulse, ts_pulse, ds_pulse};
      for (int i = 0; i < 3; i++) begin
        if (cur[i] && !prv[i]) rise_c[i] = cyc;
        if (!cur[i] && prv[i]) last_len[i] = cyc - rise_c[i];
      end
      prv = cur;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frame(input int r, input int d, input int t, input int x, input int g);
    @(negedge clk);
    t_rel = 12'(r); t_ds = 12'(d); t_ts = 12'(t); t_xf = 12'(x); gran = 2'(g);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic strobe();
    @(negedge clk); line_done = 1;
    @(negedge clk); line_done = 0;
  endtask

  task automatic burst(input int n);
    @(negedge clk); line_done = 1;
    repeat (n) @(negedge clk);
    line_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    phase = "R1";
    chk("R1 pix_rst after reset", pix_rst, 1);
    chk("R1 pulses after reset", {ds_pulse, ts_pulse, xfer_pulse}, 0);
    repeat (5) strobe();
    chk("R1 no event before frame", {ds_pulse, ts_pulse, xfer_pulse}, 0);
    chk("R1 pix_rst before frame", pix_rst, 1);

    phase = "R2";
    frame(5, 10, 20, 30, 0);
    for (int k = 0; k <= 30; k++) begin
      strobe();
      if (k == 4)  chk("R4 pix_rst before release", pix_rst, 1);
      if (k == 5)  chk("R4 pix_rst falls on release", pix_rst, 0);
      if (k == 9)  chk("R2 ds low one line early", ds_pulse, 0);
      if (k == 10) chk("R2 ds rises at line T+1", ds_pulse, 1);
      if (k == 30) begin
        chk("R2 xfer rises at line T+1", xfer_pulse, 1);
        chk("R4 pix_rst high during xfer", pix_rst, 1);
      end
    end
    idle(220);
    chk("R3 width gran0", last_len[2], 52);
    chk("R4 pix_rst stays after xfer", pix_rst, 1);

    phase = "R7";
    for (int g = 1; g < 4; g++) begin
      frame(1, 3, 3, 3, g);
      repeat (4) strobe();
      chk("R7 coincident start", {ds_pulse, ts_pulse, xfer_pulse}, 7);
      idle(220);
      chk("R3 ds width by gran", last_len[0], 48 * g + 52);
      chk("R7 ts independent width", last_len[1], 48 * g + 52);
      chk("R7 xfer independent width", last_len[2], 48 * g + 52);
    end

    phase = "R8";
    frame(100, 4, 200, 300, 0);
    @(negedge clk); t_ds = 12'd1; gran = 2'd3;
    repeat (2) strobe();
    chk("R8 mid-frame change ignored", ds_pulse, 0);
    repeat (2) strobe();
    chk("R8 old threshold before", ds_pulse, 0);
    strobe();
    chk("R8 old threshold used", ds_pulse, 1);
    idle(220);
    chk("R8 old granularity used", last_len[0], 52);

    phase = "R9";
    @(negedge clk);
    t_rel = 12'd100; t_ds = 12'd0; t_ts = 12'd200; t_xf = 12'd300; gran = 2'd0;
    frame_start = 1; line_done = 1;
    @(negedge clk);
    frame_start = 0; line_done = 0;
    chk("R9 coincident strobe dropped", ds_pulse, 0);
    strobe();
    chk("R9 count restarts at zero", ds_pulse, 1);
    idle(220);

    phase = "R10";
    frame(4095, 4095, 0, 4095, 0);
    burst(30);
    chk("R6 ts continues under strobes", ts_pulse, 1);
    burst(4065);
    chk("R10 ds not before 4096th", ds_pulse, 0);
    chk("R4 pix_rst before late release", pix_rst, 1);
    strobe();
    chk("R10 ds at 4096th strobe", ds_pulse, 1);
    chk("R4 pix_rst held by xfer only", pix_rst, 1);
    burst(60);
    chk("R5 ds not refired at saturation", ds_pulse, 0);
    chk("R4 pix_rst low after coincident xfer", pix_rst, 0);
    burst(10);
    chk("R5 no second ds pulse", ds_pulse, 0);
    chk("R6 ds full width under strobes", last_len[0], 52);

    phase = "R11";
    frame(100, 200, 300, 0, 0);
    strobe();
    chk("R11 xfer starts", xfer_pulse, 1);
    idle(10);
    frame(100, 200, 300, 0, 0);
    strobe();
    chk("R6 xfer runs across frame start", xfer_pulse, 1);
    idle(100);
    chk("R11 not restarted", xfer_pulse, 0);
    chk("R11 not extended", last_len[2], 52);

    finished = 1;
    summary();
    $finish;
  end
endmodule